// File: doc/BRIEF.md
# Configuration-Space Memory Base Address Register

This block models one memory base address register as enumeration software sees it in configuration space. A parameter makes it either a single 32-bit register or a 64-bit register split over two dwords: a low dword at select 0 and a high dword at select 1. Requests are whole dwords. On each cycle with `req_valid` high, `req_write` chooses between a write of `req_wdata` and a read. Read data comes back on the next cycle with a one-cycle valid strobe.

Only the address bits that the region size leaves free are stored. The bits below the size alignment are tied to zero. The low nibble of the low dword always reads back as fixed type bits. Because of this, software sizes the region the usual way: it writes all ones, reads back, and gets the complement of (size-1) with the type bits. The read path adds no special logic for this and has no pattern detection. The region size (as log2), the 64-bit mode and the prefetchable flag are parameters.

Top module: `cfg_mem_bar`

## Requirements
- R1: After reset the stored address is zero. A read of the low dword returns only the type nibble, and a read of the high dword returns zero.
- R2: A read request returns data on `rd_data` with `rd_valid` high for exactly the following cycle. A write request or an idle cycle gives `rd_valid` low on the following cycle.
- R3: Bits 3:0 of a low-dword write are ignored. In a low-dword read, bit 0 is 0, bit 1 is 0, bit 2 is 1 only in 64-bit mode, and bit 3 is 1 only when the region is prefetchable.
- R4: Address bits below log2(size) always read as zero, whatever value was written.
- R5: After an all-ones write to the low dword, a read of it returns bits 31:0 of ~(size-1), ORed with the type nibble.
- R6: In 64-bit mode, the high dword (select 1) holds address bits 63:32 and has no type bits. For a size up to 4 GiB all 32 bits are stored. For a larger size, the bits below log2(size)-32 read as zero.
- R7: In 64-bit mode, a write to one dword changes only that half of the stored address. The other half keeps its value.
- R8: A read returns the stored, size-masked value and nothing else. For example, an all-ones write to the high dword of a 64-bit register of at most 4 GiB reads back as 0xFFFFFFFF.
- R9: In 32-bit mode, select 1 always reads zero and writes to it are ignored.
- R10: Read requests leave the stored address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Dword select: 0 = low dword, 1 = high dword |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High for one cycle when `rd_data` answers a read |

## Verification
The assertions assume at most one request per cycle, with `req_sel` and `req_write` stable across the cycle of the request. Several properties look one cycle back at `req_sel` to decide which dword a response belongs to, so they also assume a response always follows the request that produced it. The stimulus drives every request for exactly one clock period from the falling edge, so these assumptions hold. The same request stream goes to three builds with different parameters: the default 64-bit prefetchable 4 KiB build, a 32-bit 1 MiB build, and a 64-bit 16 GiB build. One stream therefore covers both the 32-bit mode and the high-dword masking.

// File: rtl/cfg_bar_pkg.sv
`timescale 1ns/1ps
package cfg_bar_pkg;

    typedef struct packed {
        logic [31:0] word;
    } half_state_t;

    typedef struct packed {
        logic [31:0] data;
        logic        valid;
    } rsp_state_t;

    // Writable address bits of the 64-bit address for a given size.
    function automatic logic [63:0] addr_mask(input int size_log2, input bit is64);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i >= size_log2) && (is64 || (i < 32));
        end
        return m;
    endfunction

    // Read-only nibble of the low dword: {prefetch, 64-bit, 0, memory space}.
    function automatic logic [3:0] type_bits(input bit is64, input bit pf);
        return {pf, is64, 2'b00};
    endfunction

endpackage

// File: rtl/bar_half_reg.sv
`timescale 1ns/1ps
module bar_half_reg #(
    parameter logic [31:0] KEEP = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] word_q
);
    import cfg_bar_pkg::*;

    half_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.word = wdata & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_q = s_q.word;
endmodule

// File: rtl/bar_rsp.sv
`timescale 1ns/1ps
module bar_rsp #(
    parameter logic [3:0] TYPE_NIB = 4'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        rd_hi,
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    output logic [31:0] rd_data,
    output logic        rd_valid
);
    import cfg_bar_pkg::*;

    rsp_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = rd_en;
        if (rd_en) begin
            // stored low bits are already zero, so the nibble can be ORed in
            s_d.data = rd_hi ? hi_word : (lo_word | {28'd0, TYPE_NIB});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data  = s_q.data;
    assign rd_valid = s_q.valid;
endmodule

// File: rtl/cfg_mem_bar.sv
`timescale 1ns/1ps
module cfg_mem_bar #(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_64     = 1'b1,
    parameter bit PREFETCH  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_sel,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    output logic        rd_valid
);
    import cfg_bar_pkg::*;

    localparam logic [63:0] AMASK    = addr_mask(SIZE_LOG2, IS_64);
    localparam logic [31:0] LO_KEEP  = AMASK[31:0];
    localparam logic [31:0] HI_KEEP  = AMASK[63:32];
    localparam logic [3:0]  TYPE_NIB = type_bits(IS_64, PREFETCH);

    logic        wr_lo;
    logic        rd_en;
    logic [31:0] addr_lo_q;
    logic [31:0] addr_hi_q;

    assign wr_lo = req_valid & req_write & ~req_sel;
    assign rd_en = req_valid & ~req_write;

    bar_half_reg #(.KEEP(LO_KEEP)) i_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_lo),
        .wdata  (req_wdata),
        .word_q (addr_lo_q)
    );

    generate
        if (IS_64) begin : g_hi
            logic wr_hi;
            assign wr_hi = req_valid & req_write & req_sel;
            bar_half_reg #(.KEEP(HI_KEEP)) i_hi (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_hi),
                .wdata  (req_wdata),
                .word_q (addr_hi_q)
            );
        end else begin : g_no_hi
            assign addr_hi_q = '0;
        end
    endgenerate

    bar_rsp #(.TYPE_NIB(TYPE_NIB)) i_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_hi    (req_sel),
        .lo_word  (addr_lo_q),
        .hi_word  (addr_hi_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/cfg_mem_bar_chk.sv
`timescale 1ns/1ps
module cfg_mem_bar_chk #(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_64     = 1'b1,
    parameter bit PREFETCH  = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_sel,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic [31:0] addr_lo,
    input logic [31:0] addr_hi
);
    import cfg_bar_pkg::*;

    localparam logic [63:0] AMASK = addr_mask(SIZE_LOG2, IS_64);
    localparam logic [3:0]  TNIB  = type_bits(IS_64, PREFETCH);

    // R2
    rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R2
    no_rd_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R3
    type_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(req_sel)) |-> (rd_data[3:0] == TNIB));

    // R4
    unaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(req_sel)) |-> ((rd_data[31:4] & ~AMASK[31:4]) == 28'd0));

    // R7
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sel) |=> $stable(addr_hi));

    // R7
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel) |=> $stable(addr_lo));

    // R10
    read_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> ($stable(addr_lo) && $stable(addr_hi)));

    // R8
    hi_read_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_sel)) |-> (rd_data == $past(addr_hi)));

    // R9
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_64 && rd_valid && $past(req_sel)) |-> (rd_data == 32'd0));
endmodule

bind cfg_mem_bar cfg_mem_bar_chk #(
    .SIZE_LOG2 (SIZE_LOG2),
    .IS_64     (IS_64),
    .PREFETCH  (PREFETCH)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .addr_lo   (addr_lo_q),
    .addr_hi   (addr_hi_q)
);

// File: tb/test_cfg_mem_bar.sv
`timescale 1ns/1ps
module test_cfg_mem_bar;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic [31:0] req_wdata = '0;

    logic [31:0] rd_data0, rd_data1, rd_data2;
    logic        rd_valid0, rd_valid1, rd_valid2;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    // default build: 64-bit, prefetchable, 4 KiB
    cfg_mem_bar i_cfg_mem_bar (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .rd_data(rd_data0), .rd_valid(rd_valid0));

    // 32-bit, not prefetchable, 1 MiB
    cfg_mem_bar #(.SIZE_LOG2(20), .IS_64(1'b0), .PREFETCH(1'b0)) i_cfg_mem_bar_n32 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .rd_data(rd_data1), .rd_valid(rd_valid1));

    // 64-bit, not prefetchable, 16 GiB
    cfg_mem_bar #(.SIZE_LOG2(34), .IS_64(1'b1), .PREFETCH(1'b0)) i_cfg_mem_bar_big (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .rd_data(rd_data2), .rd_valid(rd_valid2));

    // behavioural reference: one 64-bit address per build
    logic [63:0] m_addr [3];
    logic [63:0] m_mask [3];
    logic [3:0]  m_type [3];

    function automatic logic [63:0] mk_mask(input int sz, input bit wide);
        logic [63:0] ones = ~((64'd1 << sz) - 64'd1);
        return wide ? ones : {32'd0, ones[31:0]};
    endfunction

    function automatic logic [31:0] act_data(input int k);
        return (k == 0) ? rd_data0 : (k == 1) ? rd_data1 : rd_data2;
    endfunction

    function automatic logic act_valid(input int k);
        return (k == 0) ? rd_valid0 : (k == 1) ? rd_valid1 : rd_valid2;
    endfunction

    task automatic check(input bit ok, input string tag, input int k,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s build%0d: actual=%h expected=%h", tag, k, act, exp);
        end
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        req_write = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++)
            check(act_valid(k) == 1'b0, tag, k, 32'(act_valid(k)), 32'd0);
    endtask

    task automatic op(input bit wr, input bit sel, input logic [31:0] d, input string tag);
        logic [31:0] exp [3];
        for (int k = 0; k < 3; k++) begin
            exp[k] = sel ? m_addr[k][63:32] : (m_addr[k][31:0] | {28'd0, m_type[k]});
            if (wr) begin
                if (sel) m_addr[k][63:32] = d & m_mask[k][63:32];
                else     m_addr[k][31:0]  = d & m_mask[k][31:0];
            end
        end
        req_valid = 1'b1;
        req_write = wr;
        req_sel   = sel;
        req_wdata = d;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(act_valid(k) == !wr, "R2", k, 32'(act_valid(k)), 32'(!wr));
            if (!wr) check(act_data(k) == exp[k], tag, k, act_data(k), exp[k]);
        end
    endtask

    initial begin
        logic [31:0] seed;
        m_mask[0] = mk_mask(12, 1'b1); m_type[0] = 4'hC;
        m_mask[1] = mk_mask(20, 1'b0); m_type[1] = 4'h0;
        m_mask[2] = mk_mask(34, 1'b1); m_type[2] = 4'h4;
        for (int k = 0; k < 3; k++) m_addr[k] = '0;

        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++)
            check(act_valid(k) == 1'b0, "R1", k, 32'(act_valid(k)), 32'd0);
        rst_n = 1'b1;
        idle("R2");

        op(1'b0, 1'b0, '0, "R1");             // low dword after reset
        op(1'b0, 1'b1, '0, "R1");             // high dword after reset

        op(1'b1, 1'b0, 32'hFFFF_FFFF, "R5");  // size probe
        op(1'b0, 1'b0, '0, "R5");
        idle("R2");
        op(1'b1, 1'b1, 32'hFFFF_FFFF, "R8");  // no pattern detection on high dword
        op(1'b0, 1'b1, '0, "R8");
        op(1'b0, 1'b1, '0, "R6");
        op(1'b0, 1'b1, '0, "R9");

        op(1'b1, 1'b0, 32'h1234_5678, "R3");  // low nibble of write ignored
        op(1'b0, 1'b0, '0, "R3");
        op(1'b0, 1'b1, '0, "R7");             // high half unchanged
        op(1'b1, 1'b1, 32'h0000_0001, "R7");
        op(1'b0, 1'b0, '0, "R7");             // low half unchanged
        op(1'b1, 1'b0, 32'hABCD_EFFF, "R4");
        op(1'b0, 1'b0, '0, "R4");
        op(1'b0, 1'b0, '0, "R10");            // back-to-back reads
        op(1'b0, 1'b1, '0, "R10");
        op(1'b0, 1'b0, '0, "R10");
        op(1'b1, 1'b1, 32'h8000_0003, "R6");
        op(1'b0, 1'b1, '0, "R6");

        seed = 32'h1D2C_3B4A;
        for (int n = 0; n < 60; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            op(seed[30], seed[29], {seed[15:0], seed[31:16]}, "R7");
            if (seed[5:4] == 2'b00) idle("R2");
        end
        idle("R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule